// File: doc/BRIEF.md
# Compressed Instruction Fetch Aligner

This block sits between a 32-bit instruction fetch port and the instruction decoder of a core that mixes 16-bit compressed and 32-bit instructions. Each cycle the fetch side may present one aligned 32-bit word. The block keeps its own program counter, finds the instruction that starts at that counter and hands it to the decoder. Every instruction comes out as a 32-bit value with a compressed flag, its own address and the next sequential address.

When a 32-bit instruction begins in the upper half of one fetch word, the block holds that half and joins it to the lower half of the following word. A pending-half flag records this. On every step the block tells the fetch side whether the present word is used up (`fw_adv`) or must stay on the port because it still holds bytes that have not been consumed. A redirect loads a new counter value and, in the same cycle, throws away any held half and any instruction waiting at the output.

Top module: `fetch_aligner`

## Requirements
- R1: After reset `out_valid` and `out_done` are 0, no half is pending, and the counter equals `RESET_PC` (default 0, word aligned).
- R2: A 16-bit parcel counts as compressed when its bits [1:0] are anything other than 2'b11. Bits [1:0] = 2'b11 mark the low half of a 32-bit instruction.
- R3: If the counter is word aligned and the low parcel is compressed, the block issues `{16'h0, word[15:0]}` with `out_cmp`=1 and keeps `fw_adv`=0, so the same word stays on the port.
- R4: If the counter is word aligned and the low parcel is not compressed, the block issues the whole word with `out_cmp`=0 and raises `fw_adv`.
- R5: If counter bit 1 is set, no half is pending and the upper parcel is compressed, the block issues `{16'h0, word[31:16]}` with `out_cmp`=1 and raises `fw_adv`.
- R6: If counter bit 1 is set, no half is pending and the upper parcel is not compressed, the block holds that parcel, sets the pending flag and raises `fw_adv`. It issues nothing in that step.
- R7: While a half is pending, the next word's low parcel becomes bits [31:16] of the held instruction. The joined instruction is issued at the held address and the flag clears. `fw_adv` stays 0, because the word's upper parcel is still unused.
- R8: `out_npc` equals `out_pc` + 2 when `out_cmp` is 1 and `out_pc` + 4 otherwise. The counter moves to `out_npc` once an instruction has been issued.
- R9: While `out_valid`=1 and `out_ready`=0, the output fields hold steady and `fw_adv` stays 0.
- R10: `out_done` is 1 for exactly one cycle, in the cycle after each handshake (`out_valid` and `out_ready` both 1) that is not overridden by a redirect.
- R11: A redirect clears the pending flag, discards the held half and any waiting output, and loads `redirect_pc` with bit 0 forced to 0. It consumes no fetch word, and the instruction at the new address comes out with nothing of the discarded half in it.
- R12: While a half is pending, bits [31:16] of the held instruction register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fw_valid | input | 1 | A fetch word is on `fw_word` |
| fw_word | input | 32 | Aligned fetch word holding the bytes at the counter |
| fw_adv | output | 1 | The present word is used up; fetch the next one |
| redirect | input | 1 | Load a new counter value and flush the block |
| redirect_pc | input | 32 | New counter value (bit 0 ignored) |
| out_valid | output | 1 | An instruction is waiting for the decoder |
| out_ready | input | 1 | The decoder takes the instruction |
| out_instr | output | 32 | Instruction; compressed ones zero-extended |
| out_cmp | output | 1 | The instruction is compressed |
| out_pc | output | 32 | Address of the instruction |
| out_npc | output | 32 | Next sequential address |
| out_done | output | 1 | One-cycle pulse after each accepted instruction |

## Verification
The bench aims at a 32-bit instruction that starts in the upper half of a word. A design that joins the halves in the wrong order, or that fetches one word too many after the join, loses a parcel, and every instruction after that comes out wrong. It also aims at compressed parcels in the low half. A design that raises `fw_adv` there skips the upper parcel. Redirects are placed while a half is pending and while an output is stalled: a leftover half would show up glued to the first instruction at the new address, and a leftover output would reach the decoder. Random ready stalls and fetch gaps check that no word is consumed, and no instruction is dropped or repeated, while the decoder is not taking instructions.

// File: rtl/fa_pkg.sv
`timescale 1ns/1ps
package fa_pkg;
   // Width of one instruction parcel; a full instruction is two parcels.
   localparam int unsigned FA_PARCEL_W = 16;

   // A parcel is short unless its two low bits are both set.
   function automatic logic parcel_is_short(input logic [1:0] op_lsb);
      return op_lsb != 2'b11;
   endfunction
endpackage

// File: rtl/fa_parcel_class.sv
`timescale 1ns/1ps
module fa_parcel_class #(
   parameter int unsigned N_PARCELS = 2
) (
   input  logic [2*N_PARCELS-1:0] op_bits,
   output logic [N_PARCELS-1:0]   is_short
);
   for (genvar g = 0; g < N_PARCELS; g++) begin : g_parcel
      assign is_short[g] = fa_pkg::parcel_is_short(op_bits[2*g +: 2]);
   end
endmodule

// File: rtl/fa_step.sv
`timescale 1ns/1ps
module fa_step #(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned PARCEL_W = 16
) (
   input  logic [WORD_W-1:0] word,
   input  logic [WORD_W-1:0] held,
   input  logic              pend,
   input  logic              pc_off,
   input  logic              short_lo,
   input  logic              short_hi,
   output logic              issue,
   output logic [WORD_W-1:0] instr,
   output logic              cmp,
   output logic              adv,
   output logic              start_pend
);
   localparam int unsigned HI_W = WORD_W - PARCEL_W;

   logic [PARCEL_W-1:0] lo_par;
   logic [HI_W-1:0]     hi_par;

   assign lo_par = word[PARCEL_W-1:0];
   assign hi_par = word[WORD_W-1:PARCEL_W];

   always_comb begin
      issue      = 1'b0;
      instr      = '0;
      cmp        = 1'b0;
      adv        = 1'b0;
      start_pend = 1'b0;
      if (pend) begin
         // join: new low parcel fills the upper half of the held value
         issue = 1'b1;
         instr = {lo_par, {PARCEL_W{1'b0}}} | held;
      end else if (!pc_off) begin
         issue = 1'b1;
         if (short_lo) begin
            instr = {{HI_W{1'b0}}, lo_par};
            cmp   = 1'b1;
         end else begin
            instr = word;
            adv   = 1'b1;
         end
      end else begin
         adv = 1'b1;
         if (short_hi) begin
            issue = 1'b1;
            instr = {{PARCEL_W{1'b0}}, hi_par};
            cmp   = 1'b1;
         end else begin
            start_pend = 1'b1;
         end
      end
   end
endmodule

// File: rtl/fa_out_stage.sv
`timescale 1ns/1ps
module fa_out_stage #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned PC_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              flush,
   input  logic              ready,
   input  logic [WORD_W-1:0] in_instr,
   input  logic              in_cmp,
   input  logic [PC_W-1:0]   in_pc,
   input  logic [PC_W-1:0]   in_npc,
   output logic              valid,
   output logic [WORD_W-1:0] instr,
   output logic              cmp,
   output logic [PC_W-1:0]   pc,
   output logic [PC_W-1:0]   npc,
   output logic              done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         instr <= '0;
         cmp   <= 1'b0;
         pc    <= '0;
         npc   <= '0;
         done  <= 1'b0;
      end else begin
         done <= valid && ready && !flush;
         if (flush) begin
            valid <= 1'b0;
         end else if (load) begin
            valid <= 1'b1;
            instr <= in_instr;
            cmp   <= in_cmp;
            pc    <= in_pc;
            npc   <= in_npc;
         end else if (ready) begin
            valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/fetch_aligner.sv
`timescale 1ns/1ps
module fetch_aligner #(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned PC_W     = 32,
   parameter logic [31:0] RESET_PC = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fw_valid,
   input  logic [WORD_W-1:0] fw_word,
   output logic              fw_adv,
   input  logic              redirect,
   input  logic [PC_W-1:0]   redirect_pc,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_instr,
   output logic              out_cmp,
   output logic [PC_W-1:0]   out_pc,
   output logic [PC_W-1:0]   out_npc,
   output logic              out_done
);
   localparam int unsigned PARCEL_W  = fa_pkg::FA_PARCEL_W;
   localparam int unsigned N_PARCELS = WORD_W / PARCEL_W;
   localparam logic [PC_W-1:0] STEP_S = PC_W'(PARCEL_W / 8);
   localparam logic [PC_W-1:0] STEP_L = PC_W'(WORD_W / 8);

   if (WORD_W != 2 * PARCEL_W) begin : g_bad_word
      $error("fetch_aligner: WORD_W must hold exactly two parcels");
   end
   if (PC_W < 3) begin : g_bad_pc
      $error("fetch_aligner: PC_W too narrow");
   end
   if (RESET_PC[1:0] != 2'b00) begin : g_bad_reset
      $error("fetch_aligner: RESET_PC must be word aligned");
   end

   logic [PC_W-1:0]      cur_pc;
   logic                 pend_q;
   logic [WORD_W-1:0]    held_q;
   logic [2*N_PARCELS-1:0] op_bits;
   logic [N_PARCELS-1:0] short_v;
   logic                 st_issue, st_cmp, st_adv, st_start;
   logic [WORD_W-1:0]    st_instr;
   logic [PC_W-1:0]      st_npc;
   logic                 proceed;

   for (genvar g = 0; g < N_PARCELS; g++) begin : g_op
      assign op_bits[2*g +: 2] = fw_word[g*PARCEL_W +: 2];
   end

   fa_parcel_class #(.N_PARCELS(N_PARCELS)) u_class (
      .op_bits  (op_bits),
      .is_short (short_v)
   );

   fa_step #(.WORD_W(WORD_W), .PARCEL_W(PARCEL_W)) u_step (
      .word       (fw_word),
      .held       (held_q),
      .pend       (pend_q),
      .pc_off     (cur_pc[1]),
      .short_lo   (short_v[0]),
      .short_hi   (short_v[1]),
      .issue      (st_issue),
      .instr      (st_instr),
      .cmp        (st_cmp),
      .adv        (st_adv),
      .start_pend (st_start)
   );

   assign proceed = fw_valid && !redirect && (!out_valid || out_ready);
   assign fw_adv  = proceed && st_adv;
   assign st_npc  = cur_pc + (st_cmp ? STEP_S : STEP_L);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_pc <= RESET_PC[PC_W-1:0];
         pend_q <= 1'b0;
         held_q <= '0;
      end else if (redirect) begin
         cur_pc <= redirect_pc & ~PC_W'(1);
         pend_q <= 1'b0;
         held_q <= '0;
      end else if (proceed) begin
         if (st_start) begin
            pend_q <= 1'b1;
            held_q <= {{PARCEL_W{1'b0}}, fw_word[WORD_W-1:PARCEL_W]};
         end else if (st_issue) begin
            cur_pc <= st_npc;
            pend_q <= 1'b0;
            held_q <= '0;
         end
      end
   end

   fa_out_stage #(.WORD_W(WORD_W), .PC_W(PC_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (proceed && st_issue),
      .flush    (redirect),
      .ready    (out_ready),
      .in_instr (st_instr),
      .in_cmp   (st_cmp),
      .in_pc    (cur_pc),
      .in_npc   (st_npc),
      .valid    (out_valid),
      .instr    (out_instr),
      .cmp      (out_cmp),
      .pc       (out_pc),
      .npc      (out_npc),
      .done     (out_done)
   );
endmodule

// File: rtl/fetch_aligner_chk.sv
`timescale 1ns/1ps
module fetch_aligner_chk #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned PC_W   = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fw_adv,
   input logic              redirect,
   input logic              out_valid,
   input logic              out_ready,
   input logic [WORD_W-1:0] out_instr,
   input logic              out_cmp,
   input logic [PC_W-1:0]   out_pc,
   input logic [PC_W-1:0]   out_npc,
   input logic              out_done,
   input logic              pend,
   input logic [WORD_W-1:0] held
);
   localparam int unsigned HALF = WORD_W / 2;

   // R2, R3: a short instruction is zero-extended and carries a short opcode
   p_short_form_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_cmp |-> out_instr[WORD_W-1:HALF] == '0 && out_instr[1:0] != 2'b11);

   // R2, R4: a full-width instruction carries the long opcode marker
   p_long_form_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_cmp |-> out_instr[1:0] == 2'b11);

   // R6: starting a pending half issues nothing
   p_pend_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> !out_valid);

   // R8: next address follows the instruction size
   p_npc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_npc == out_pc + (out_cmp ? PC_W'(2) : PC_W'(4)));

   // R9: a stalled output holds steady
   p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready && !redirect |=>
         out_valid && $stable(out_instr) && $stable(out_pc) && $stable(out_cmp));

   // R9: no word is consumed while the output is stalled
   p_stall_noadv_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !fw_adv);

   // R10: a done pulse follows a real handshake
   p_done_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |-> $past(out_valid && out_ready && !redirect));

   // R11: a redirect empties the output and the pending half
   p_flush_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |=> !out_valid && !pend);

   // R11: a redirect consumes no fetch word
   p_flush_noadv_r11: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |-> !fw_adv);

   // R12: upper half of the held value is empty before the join
   p_held_upper_r12: assert property (@(posedge clk) disable iff (!rst_n)
      pend |-> held[WORD_W-1:HALF] == '0);
endmodule

bind fetch_aligner fetch_aligner_chk #(.WORD_W(WORD_W), .PC_W(PC_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .fw_adv    (fw_adv),
   .redirect  (redirect),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_instr (out_instr),
   .out_cmp   (out_cmp),
   .out_pc    (out_pc),
   .out_npc   (out_npc),
   .out_done  (out_done),
   .pend      (pend_q),
   .held      (held_q)
);

// File: tb/fetch_aligner_tb_top.sv
`timescale 1ns/1ps
module fetch_aligner_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        fw_valid;
   logic [31:0] fw_word;
   logic        fw_adv;
   logic        redirect;
   logic [31:0] redirect_pc;
   logic        out_valid;
   logic        out_ready;
   logic [31:0] out_instr;
   logic        out_cmp;
   logic [31:0] out_pc;
   logic [31:0] out_npc;
   logic        out_done;

   int n_cmp = 0;
   int n_bad = 0;

   logic [15:0] par [0:127];

   always #5 clk = ~clk;

   fetch_aligner dut_i (
      .clk(clk), .rst_n(rst_n), .fw_valid(fw_valid), .fw_word(fw_word),
      .fw_adv(fw_adv), .redirect(redirect), .redirect_pc(redirect_pc),
      .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr),
      .out_cmp(out_cmp), .out_pc(out_pc), .out_npc(out_npc), .out_done(out_done)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mem_word(input int wi);
      return {par[(2*wi+1) % 128], par[(2*wi) % 128]};
   endfunction

   function automatic logic is_short(input logic [15:0] p);
      return p[1:0] != 2'b11;
   endfunction

   // expected instruction at address pc, from the parcel image
   function automatic logic [31:0] gold_instr(input logic [31:0] pc);
      int p = int'((pc >> 1) % 128);
      if (is_short(par[p])) return {16'h0, par[p]};
      return {par[(p+1) % 128], par[p]};
   endfunction

   function automatic logic [31:0] gold_npc(input logic [31:0] pc);
      int p = int'((pc >> 1) % 128);
      return pc + (is_short(par[p]) ? 32'd2 : 32'd4);
   endfunction

   task automatic expect_out(input string req, input logic [31:0] ins,
                             input logic c, input logic [31:0] pc, input logic [31:0] npc);
      chk(req, {31'b0, out_valid}, 32'd1);
      chk(req, out_instr, ins);
      chk(req, {31'b0, out_cmp}, {31'b0, c});
      chk(req, out_pc, pc);
      chk(req, out_npc, npc);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] gold_pc;
      int          wi;
      logic        exp_done;

      rst_n = 1'b0; fw_valid = 1'b0; fw_word = '0; redirect = 1'b0;
      redirect_pc = '0; out_ready = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 valid", {31'b0, out_valid}, 32'd0);
      chk("R1 done",  {31'b0, out_done},  32'd0);
      rst_n = 1'b1;

      // ---- directed corner cases ----
      out_ready = 1'b1; fw_valid = 1'b1;
      fw_word = 32'h5673_1230;                 // low short, high starts long
      #1 chk("R3 adv", {31'b0, fw_adv}, 32'd0);
      @(negedge clk);
      expect_out("R3", 32'h0000_1230, 1'b1, 32'd0, 32'd2);
      #1 chk("R6 adv", {31'b0, fw_adv}, 32'd1);
      @(negedge clk);
      chk("R6 no issue", {31'b0, out_valid}, 32'd0);
      chk("R10 done", {31'b0, out_done}, 32'd1);
      fw_word = 32'h4441_8888;                 // low joins, high short
      #1 chk("R7 adv", {31'b0, fw_adv}, 32'd0);
      @(negedge clk);
      expect_out("R7 R8", 32'h8888_5673, 1'b0, 32'd2, 32'd6);
      #1 chk("R5 adv", {31'b0, fw_adv}, 32'd1);
      @(negedge clk);
      expect_out("R5", 32'h0000_4441, 1'b1, 32'd6, 32'd8);
      fw_word = 32'h1111_2223;                 // aligned long
      #1 chk("R4 adv", {31'b0, fw_adv}, 32'd1);
      @(negedge clk);
      expect_out("R4", 32'h1111_2223, 1'b0, 32'd8, 32'd12);
      out_ready = 1'b0;
      fw_word = 32'h7FFF_0001;
      #1 chk("R9 adv", {31'b0, fw_adv}, 32'd0);
      @(negedge clk);
      expect_out("R9 hold", 32'h1111_2223, 1'b0, 32'd8, 32'd12);
      chk("R10 no done", {31'b0, out_done}, 32'd0);
      out_ready = 1'b1;
      #1 chk("R3 adv2", {31'b0, fw_adv}, 32'd0);
      @(negedge clk);
      expect_out("R3 after stall", 32'h0000_0001, 1'b1, 32'd12, 32'd14);
      #1 chk("R6 adv2", {31'b0, fw_adv}, 32'd1);
      @(negedge clk);
      chk("R6 pending", {31'b0, out_valid}, 32'd0);
      redirect = 1'b1; redirect_pc = 32'h0000_0041;   // bit 0 ignored
      fw_word = 32'h3333_4445;
      #1 chk("R11 adv", {31'b0, fw_adv}, 32'd0);
      @(negedge clk);
      redirect = 1'b0;
      chk("R11 empty", {31'b0, out_valid}, 32'd0);
      #1 chk("R11 adv after", {31'b0, fw_adv}, 32'd0);
      @(negedge clk);
      expect_out("R11 no leak", 32'h0000_4445, 1'b1, 32'h40, 32'h42);
      out_ready = 1'b0; redirect = 1'b1; redirect_pc = 32'h80;
      @(negedge clk);
      redirect = 1'b0; fw_valid = 1'b0;
      chk("R11 drop", {31'b0, out_valid}, 32'd0);
      @(negedge clk);
      chk("R10 flush no done", {31'b0, out_done}, 32'd0);

      // ---- random stream against the parcel image ----
      void'($urandom(32'd2024));
      for (int i = 0; i < 128; i++) par[i] = 16'($urandom);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      gold_pc = 32'd0; wi = 0; exp_done = 1'b0;
      for (int c = 0; c < 3000; c++) begin
         logic rd, fv, rdy, acc;
         logic [31:0] rpc;
         @(negedge clk);
         chk("R10 pulse", {31'b0, out_done}, {31'b0, exp_done});
         rd  = ($urandom % 100) < 2;
         fv  = ($urandom % 100) < 80;
         rdy = ($urandom % 100) < 70;
         rpc = $urandom & 32'h0000_0FFF;
         fw_valid = fv; fw_word = mem_word(wi);
         redirect = rd; redirect_pc = rpc; out_ready = rdy;
         #1;
         acc = out_valid && rdy && !rd;
         if (acc) begin
            chk("R2 R7 R8 instr", out_instr, gold_instr(gold_pc));
            chk("R8 pc", out_pc, gold_pc);
            chk("R8 npc", out_npc, gold_npc(gold_pc));
            chk("R2 cmp", {31'b0, out_cmp},
                {31'b0, is_short(par[int'((gold_pc >> 1) % 128)])});
            gold_pc = gold_npc(gold_pc);
         end
         if (rd) begin
            chk("R11 adv", {31'b0, fw_adv}, 32'd0);
            gold_pc = rpc & ~32'd1;
            wi = int'((rpc >> 2) % 64);
         end else if (fw_adv) begin
            wi = (wi + 1) % 64;
         end
         exp_done = acc;
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule